// File: doc/BRIEF.md
# Audio Serial Port Master Transmitter

This block is the clock-master end of a two-channel serial audio link. From its core clock it derives a bit clock and a frame clock and sends a pair of 24-bit two's-complement samples per frame, one for the left channel and one for the right, MSB first. Each frame is always 64 bit clocks long. One slot decoder serves both the left-justified and the I2S framing. A two-bit speed code sets the clock ratios. An optional enable halves the master rate before any other logic sees it.

The core clock input `mclk` runs at twice the nominal master clock rate. One master-clock period is therefore two core cycles, or four when the halving enable is set. With this choice every generated clock, including the quad-speed bit clock that equals the master clock, leaves the block as a registered signal. The user presents a sample pair with a one-cycle strobe at any time. The pair waits in a holding register and goes out starting at the next frame boundary. After reset the serial data stays low for a programmable number of frames while the converter front end settles.

Top module: `aud_ser_master`

## Requirements
- R1: Speed code `spd_sel` 2'b00, 2'b01 and 2'b10 give bit-clock periods of 8, 4 and 2 core cycles when `pre_div_en` is 0. The frame clock period is always 64 bit clocks, which equals 512, 256 or 128 core cycles (256, 128 or 64 master periods).
- R2: With `pre_div_en` = 1 every bit-clock and frame-clock period is exactly doubled.
- R3: `fclk_o` and `sdata_o` change only on a falling edge of `bclk_o`. They hold steady for the whole high phase of the bit clock.
- R4: When `fmt_i2s` = 0 (left-justified), `fclk_o` is high for the left half (slots 0-31) and low for the right half (slots 32-63). Data bit 23 goes in slot 0 of a half and bit 0 in slot 23. Slots 24-31 of each half are low.
- R5: When `fmt_i2s` = 1 (I2S), `fclk_o` is low for the left half and high for the right half. Slot 0 of each half is low, bits 23..0 occupy slots 1-24, and slots 25-31 are low.
- R6: Each half-frame lasts exactly 32 bit clocks: `fclk_o` toggles once every 32 falling bit-clock edges.
- R7: A pair strobed in with `smp_valid` is used starting at the next frame boundary. A pair that arrives mid-frame does not alter the frame in progress. Sample inputs present while `smp_valid` is 0 are ignored.
- R8: The first `HOLD_FRAMES` frames after reset carry all-zero serial data. The frame clock still runs during these frames.
- R9: While `rst` is high all three outputs are low. After release the bit clock rises after one half period. The first falling edge opens slot 0 of a left half.
- R10: Speed code 2'b11 is invalid. While it is applied all outputs are low, and the block restarts as after a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Core clock, twice the nominal master clock rate |
| rst | input | 1 | Synchronous active-high reset |
| spd_sel | input | 2 | Speed code: 00 single, 01 double, 10 quad, 11 invalid |
| pre_div_en | input | 1 | Halve the master rate before all other logic |
| fmt_i2s | input | 1 | 0 left-justified, 1 I2S framing |
| smp_valid | input | 1 | One-cycle strobe: capture the sample pair |
| smp_left | input | 24 | Left-channel sample, two's complement |
| smp_right | input | 24 | Right-channel sample, two's complement |
| bclk_o | output | 1 | Bit clock |
| fclk_o | output | 1 | Frame (left/right) clock |
| sdata_o | output | 1 | Serial data, MSB first |

## Verification
The bench instantiates the block with `HOLD_FRAMES` set to 2 instead of the production value of 2500. This places the first frame with live data as the third frame after reset. Within four frames of each run, the bench therefore observes the silent hold-off, the first captured pair, and a pair that replaces it mid-frame. Five combinations of speed code, halving enable and framing are each run from reset, and a final step drives the invalid speed code into a running link.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

    localparam int SAMPLE_W   = 24;
    localparam int SLOT_W     = 6;
    localparam int HALF_W     = SLOT_W - 1;
    localparam int PRE_W      = 4;
    localparam int IDX_W      = $clog2(SAMPLE_W);

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_RSVD   = 2'b11
    } speed_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } pair_t;

    // Core cycles per bit-clock half period.
    function automatic logic [PRE_W-1:0] half_ticks(speed_e spd, logic halve);
        logic [PRE_W-1:0] base;
        case (spd)
            SPD_SINGLE: base = PRE_W'(4);
            SPD_DOUBLE: base = PRE_W'(2);
            default:    base = PRE_W'(1);
        endcase
        return halve ? (base << 1) : base;
    endfunction

    // Serial bit carried in a slot of the frame for either framing.
    function automatic logic slot_bit(pair_t p, logic [SLOT_W-1:0] slot, logic i2s);
        logic [SAMPLE_W-1:0] word;
        int pos;
        int idx;
        word = slot[SLOT_W-1] ? p.right : p.left;
        pos  = int'(slot[HALF_W-1:0]);
        idx  = i2s ? (SAMPLE_W - pos) : (SAMPLE_W - 1 - pos);
        if (idx >= 0 && idx < SAMPLE_W)
            return word[idx[IDX_W-1:0]];
        return 1'b0;
    endfunction

endpackage

// File: rtl/aud_clk_gen.sv
module aud_clk_gen
    import aud_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  speed_e            spd,
    input  logic              halve,
    output logic              bclk,
    output logic              fall,
    output logic [SLOT_W-1:0] slot_nxt
);
    logic [PRE_W-1:0]  pcnt;
    logic [PRE_W-1:0]  lim;
    logic [SLOT_W-1:0] slot;
    logic              tick;

    assign lim      = half_ticks(spd, halve) - PRE_W'(1);
    assign tick     = (pcnt >= lim);
    assign fall     = tick & bclk;
    assign slot_nxt = slot + SLOT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
            bclk <= 1'b0;
            slot <= '1;
        end else if (tick) begin
            pcnt <= '0;
            bclk <= ~bclk;
            if (bclk)
                slot <= slot_nxt;
        end else begin
            pcnt <= pcnt + PRE_W'(1);
        end
    end
endmodule

// File: rtl/aud_frame_ctrl.sv
module aud_frame_ctrl
    import aud_ser_pkg::*;
#(
    parameter int HOLD_FRAMES = 2500
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  pair_t in_pair,
    input  logic  boundary,
    output pair_t use_pair,
    output logic  use_live
);
    localparam int HCNT_W = (HOLD_FRAMES < 1) ? 1 : $clog2(HOLD_FRAMES + 1);

    pair_t             pending;
    pair_t             active;
    logic              live;
    logic [HCNT_W-1:0] hcnt;
    logic              hold_done;

    assign hold_done = (hcnt == HCNT_W'(HOLD_FRAMES));
    assign use_pair  = boundary ? pending   : active;
    assign use_live  = boundary ? hold_done : live;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            active  <= '0;
            live    <= 1'b0;
            hcnt    <= '0;
        end else begin
            if (in_valid)
                pending <= in_pair;
            if (boundary) begin
                active <= pending;
                live   <= hold_done;
                if (!hold_done)
                    hcnt <= hcnt + HCNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/aud_shifter.sv
module aud_shifter
    import aud_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fall,
    input  logic [SLOT_W-1:0] slot_nxt,
    input  logic              i2s,
    input  pair_t             pair,
    input  logic              live,
    output logic              fclk,
    output logic              sdata
);
    logic right_half;

    assign right_half = slot_nxt[SLOT_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            fclk  <= 1'b0;
            sdata <= 1'b0;
        end else if (fall) begin
            fclk  <= i2s ? right_half : ~right_half;
            sdata <= live & slot_bit(pair, slot_nxt, i2s);
        end
    end
endmodule

// File: rtl/aud_ser_master.sv
module aud_ser_master
    import aud_ser_pkg::*;
#(
    parameter int HOLD_FRAMES = 2500
) (
    input  logic                mclk,
    input  logic                rst,
    input  logic [1:0]          spd_sel,
    input  logic                pre_div_en,
    input  logic                fmt_i2s,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    output logic                bclk_o,
    output logic                fclk_o,
    output logic                sdata_o
);
    speed_e            spd;
    logic              bad_code;
    logic              core_rst;
    logic              bclk_r;
    logic              fclk_r;
    logic              sdata_r;
    logic              fall;
    logic [SLOT_W-1:0] slot_nxt;
    logic              boundary;
    pair_t             in_pair;
    pair_t             use_pair;
    logic              use_live;

    assign spd      = speed_e'(spd_sel);
    assign bad_code = (spd == SPD_RSVD);
    assign core_rst = rst | bad_code;
    assign boundary = fall && (slot_nxt == '0);
    assign in_pair  = '{left: smp_left, right: smp_right};

    aud_clk_gen u_clk (
        .clk      (mclk),
        .rst      (core_rst),
        .spd      (spd),
        .halve    (pre_div_en),
        .bclk     (bclk_r),
        .fall     (fall),
        .slot_nxt (slot_nxt)
    );

    aud_frame_ctrl #(.HOLD_FRAMES(HOLD_FRAMES)) u_frm (
        .clk      (mclk),
        .rst      (core_rst),
        .in_valid (smp_valid),
        .in_pair  (in_pair),
        .boundary (boundary),
        .use_pair (use_pair),
        .use_live (use_live)
    );

    aud_shifter u_shf (
        .clk      (mclk),
        .rst      (core_rst),
        .fall     (fall),
        .slot_nxt (slot_nxt),
        .i2s      (fmt_i2s),
        .pair     (use_pair),
        .live     (use_live),
        .fclk     (fclk_r),
        .sdata    (sdata_r)
    );

    assign bclk_o  = bclk_r  & ~bad_code;
    assign fclk_o  = fclk_r  & ~bad_code;
    assign sdata_o = sdata_r & ~bad_code;
endmodule

// File: rtl/aud_ser_master_chk.sv
module aud_ser_master_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] spd_sel,
    input logic       fmt_i2s,
    input logic       bclk,
    input logic       fclk,
    input logic       sdata
);
    logic       bclk_q;
    logic       fclk_q;
    logic       sdata_q;
    logic       hold;
    logic       fall;
    logic       fchg;
    logic       seen_r;
    logic       seen_now;
    logic [5:0] pos_r;
    logic [5:0] pos_now;

    always_ff @(posedge clk) begin
        bclk_q  <= bclk;
        fclk_q  <= fclk;
        sdata_q <= sdata;
    end

    assign hold     = rst || (spd_sel == 2'b11);
    assign fall     = bclk_q && !bclk;
    assign fchg     = fclk != fclk_q;
    assign seen_now = seen_r || (fall && fchg);
    assign pos_now  = fall ? (fchg ? 6'd0 : pos_r + 6'd1) : pos_r;

    always_ff @(posedge clk) begin
        if (hold) begin
            seen_r <= 1'b0;
            pos_r  <= '0;
        end else if (fall) begin
            seen_r <= seen_now;
            pos_r  <= pos_now;
        end
    end

    assert_edge_align_R3: assert property (@(posedge clk) disable iff (hold)
        (fchg || (sdata != sdata_q)) |-> fall);

    assert_half_len_R6: assert property (@(posedge clk) disable iff (hold)
        (fall && fchg && seen_r) |-> (pos_r == 6'd31));

    assert_lj_tail_R4: assert property (@(posedge clk) disable iff (hold)
        (seen_now && !fmt_i2s && pos_now >= 6'd24) |-> !sdata);

    assert_i2s_pad_R5: assert property (@(posedge clk) disable iff (hold)
        (seen_now && fmt_i2s && (pos_now == 6'd0 || pos_now >= 6'd25)) |-> !sdata);

    assert_reset_quiet_R9: assert property (@(posedge clk)
        rst |=> (!bclk && !fclk && !sdata));

    assert_bad_code_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (spd_sel == 2'b11) |=> (!bclk && !fclk && !sdata));
endmodule

bind aud_ser_master aud_ser_master_chk u_chk (
    .clk     (mclk),
    .rst     (rst),
    .spd_sel (spd_sel),
    .fmt_i2s (fmt_i2s),
    .bclk    (bclk_o),
    .fclk    (fclk_o),
    .sdata   (sdata_o)
);

// File: tb/sim_aud_ser_master.sv
`timescale 1ns/1ps
module sim_aud_ser_master;
    logic        mclk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  spd_sel = 2'b00;
    logic        pre_div_en = 1'b0;
    logic        fmt_i2s = 1'b0;
    logic        smp_valid = 1'b0;
    logic [23:0] smp_left = '0;
    logic [23:0] smp_right = '0;
    logic        bclk_o;
    logic        fclk_o;
    logic        sdata_o;

    int checks = 0;
    int errors = 0;
    int cur_h = 4;
    int n_seen = 0;
    bit mon_en = 1'b0;
    logic [1:0] exp_q[$];
    string      tag_q[$];

    localparam logic [23:0] A_L = 24'h9A5C3F, A_R = 24'h3C81E7;
    localparam logic [23:0] B_L = 24'h7FFFFF, B_R = 24'h800001;

    always #10 mclk = ~mclk;

    aud_ser_master #(.HOLD_FRAMES(2)) u0 (
        .mclk(mclk), .rst(rst), .spd_sel(spd_sel), .pre_div_en(pre_div_en),
        .fmt_i2s(fmt_i2s), .smp_valid(smp_valid), .smp_left(smp_left),
        .smp_right(smp_right), .bclk_o(bclk_o), .fclk_o(fclk_o), .sdata_o(sdata_o)
    );

    task automatic check_bit(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Driver side of the scoreboard: one expected (fclk, sdata) item per bit slot.
    task automatic push_frame(input logic [23:0] l, input logic [23:0] r,
                              input bit live, input bit i2s, input string tag);
        for (int s = 0; s < 64; s++) begin
            logic        ch;
            int          p;
            logic [23:0] w;
            logic        fc;
            logic        sd;
            ch = (s >= 32);
            p  = s % 32;
            w  = ch ? r : l;
            fc = i2s ? ch : !ch;
            sd = 1'b0;
            if (live) begin
                if (!i2s && p < 24)            sd = w[23 - p];
                if (i2s && p >= 1 && p <= 24)  sd = w[24 - p];
            end
            exp_q.push_back({fc, sd});
            tag_q.push_back(tag);
        end
    endtask

    // Monitor: compare at each bit-clock rise, then confirm the values hold (R3).
    initial begin
        forever begin
            @(posedge bclk_o);
            if (mon_en && exp_q.size() > 0) begin
                logic [1:0] e;
                string      t;
                logic       f1;
                logic       s1;
                #5;
                e  = exp_q.pop_front();
                t  = tag_q.pop_front();
                f1 = fclk_o;
                s1 = sdata_o;
                check_bit(t, "frame clock", f1, e[1]);
                check_bit(t, "serial data", s1, e[0]);
                #(cur_h * 20 - 10);
                check_bit("R3", "frame clock held while bclk high", fclk_o, f1);
                check_bit("R3", "data held while bclk high", sdata_o, s1);
                n_seen++;
            end
        end
    end

    task automatic drive_pair(input logic [23:0] l, input logic [23:0] r);
        @(negedge mclk);
        smp_valid = 1'b1;
        smp_left  = l;
        smp_right = r;
        @(negedge mclk);
        smp_valid = 1'b0;
        smp_left  = 24'h555555;   // R7: ignored without the strobe
        smp_right = 24'hAAAAAA;
    endtask

    task automatic run_cfg(input logic [1:0] spd, input logic dv, input logic fi);
        realtime t0;
        realtime t1;
        int      h;
        mon_en     = 1'b0;
        rst        = 1'b1;
        spd_sel    = spd;
        pre_div_en = dv;
        fmt_i2s    = fi;
        smp_valid  = 1'b0;
        h = ((spd == 2'b00) ? 4 : (spd == 2'b01) ? 2 : 1) * (dv ? 2 : 1);
        cur_h = h;
        repeat (3) @(negedge mclk);
        check_bit("R9", "bclk in reset", bclk_o, 1'b0);
        check_bit("R9", "fclk in reset", fclk_o, 1'b0);
        check_bit("R9", "sdata in reset", sdata_o, 1'b0);
        exp_q.delete();
        tag_q.delete();
        n_seen = 0;
        exp_q.push_back(2'b00);   // R9: rise before slot 0
        tag_q.push_back("R9");
        push_frame(24'h0, 24'h0, 1'b0, fi, "R8");
        push_frame(24'h0, 24'h0, 1'b0, fi, "R8");
        push_frame(A_L, A_R, 1'b1, fi, fi ? "R5" : "R4");
        push_frame(B_L, B_R, 1'b1, fi, "R7");
        mon_en = 1'b1;
        rst = 1'b0;
        wait (n_seen >= 5);
        drive_pair(A_L, A_R);
        wait (n_seen >= 10);
        @(posedge bclk_o); t0 = $realtime;
        @(posedge bclk_o); t1 = $realtime;
        checks++;
        if ((t1 - t0) != real'(40 * h)) begin
            errors++;
            $display("FAIL %s bit clock period actual=%0t expected=%0d", dv ? "R2" : "R1", t1 - t0, 40 * h);
        end
        wait (n_seen >= 169);     // mid-frame 2, right half
        drive_pair(B_L, B_R);
        wait (n_seen >= 257);
        mon_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge mclk);
        errors++;
        $display("FAIL watchdog: run did not complete actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        run_cfg(2'b00, 1'b0, 1'b0);
        run_cfg(2'b01, 1'b1, 1'b1);
        run_cfg(2'b10, 1'b0, 1'b1);
        run_cfg(2'b10, 1'b1, 1'b0);
        run_cfg(2'b00, 1'b1, 1'b1);
        // R10: invalid speed code applied to a running link
        @(negedge mclk);
        spd_sel = 2'b11;
        @(negedge mclk);
        for (int i = 0; i < 20; i++) begin
            check_bit("R10", "bclk invalid code", bclk_o, 1'b0);
            check_bit("R10", "fclk invalid code", fclk_o, 1'b0);
            check_bit("R10", "sdata invalid code", sdata_o, 1'b0);
            @(negedge mclk);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule